// File: doc/BRIEF.md
# Four-Lane I2S Clock Generator and Serializer

This block runs entirely from a master oscillator clock at 256 times the audio sample rate. It drives that clock straight out again as the converter system clock. From the same clock it derives three others: a bit clock at one quarter of the master rate, a word clock at the sample rate, and a divide-by-256 feedback clock that goes back to the phase comparator of the external PLL. Because all three come from one set of counters, they keep a fixed phase relationship to each other.

Four serial data lanes leave the block in lockstep. Each lane sends one stereo pair per word-clock frame in the usual I2S format. The left channel goes out while the word clock is low and the right channel while it is high. Each channel takes a 32-bit slot: the 24-bit sample is sent most significant bit first, starting one bit-clock period after the word-clock edge, and zeros fill the rest of the slot.

All eight samples are captured together at the start of every frame. A one-cycle request strobe tells the upstream logic when to present the next set. Two static outputs tell the converter which speed range to use.

Top module: `i2s_quad_tx`

## Requirements
- R1: `sysclk_o` equals `clk_mclk_i` at all times; it is a combinational pass-through.
- R2: `bclk_o` has a period of 4 master cycles. With the frame counter c (master cycles since the last frame start, 0..255), `bclk_o` is low for c mod 4 in {0,1} and high for c mod 4 in {2,3}. It falls on every bit boundary.
- R3: `wclk_o` is low during bit periods 0..31 of the 64-bit frame (left) and high during bit periods 32..63 (right). It changes only in the cycle in which `bclk_o` falls.
- R4: `fbclk_o` is the master clock divided by 256. It is low for c in 0..127 and high for c in 128..255.
- R5: Lane k sends `left_i[24k+23:24k]` and `right_i[24k+23:24k]`. In bit period b, it outputs left bit 24-b for b in 1..24 and right bit 56-b for b in 33..56. In every other bit period, including bit 0, it outputs 0.
- R6: `sd_o` changes only in the cycle in which `bclk_o` falls.
- R7: Each frame uses the values on `left_i`/`right_i` at the master edge that ends cycle c=3. Changes to these inputs at any other time have no effect on that frame.
- R8: `frame_req_o` is high for exactly one master cycle, at c=0 of every frame except the first frame after reset. At that point `wclk_o` and `bclk_o` are both low.
- R9: `rate_o` is constant and set by parameter RATE_MULT: 1 gives 2'b00, 2 gives 2'b01, 4 gives 2'b10. The default is 2, which gives 2'b01.
- R10: The synchronous reset `rst_i` forces `bclk_o`, `wclk_o`, `fbclk_o`, `sd_o` and `frame_req_o` low. After release, the first master edge starts counting from c=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk_i | input | 1 | Master clock, 256x sample rate |
| rst_i | input | 1 | Synchronous active-high reset |
| left_i | input | 96 | Left samples, 24 bits per lane, lane 0 in the low bits |
| right_i | input | 96 | Right samples, 24 bits per lane, lane 0 in the low bits |
| sysclk_o | output | 1 | Converter system clock (master clock passed through) |
| bclk_o | output | 1 | Bit clock, 64x sample rate |
| wclk_o | output | 1 | Word clock, low = left |
| fbclk_o | output | 1 | PLL feedback clock, master clock divided by 256 |
| sd_o | output | 4 | Serial data, one bit per lane |
| rate_o | output | 2 | Static converter speed-range select |
| frame_req_o | output | 1 | One-cycle request for the next frame's samples |

## Verification
The bench steps through every master cycle of many frames and checks every output in every cycle against a model based on the frame counter.

- **Sample patterns.** The patterns include all ones, a lone MSB, a lone LSB and alternating bits. A serializer that is off by one bit, or that swaps the channels, puts a one into a padding bit or bit 0, or moves the MSB.
- **Input changes after capture.** Part-way through some frames, the inputs change to garbage. A design that reads the inputs live instead of latching them would put that garbage on the wire.
- **Reset in mid-frame.** A reset arrives in the middle of a frame. It checks that every divider returns to phase zero, and that the first frame after reset sends its samples with no request pulse. A divider left running through reset would skew the feedback clock against the word clock.

// File: rtl/i2s_quad_pkg.sv
`timescale 1ns/1ps
package i2s_quad_pkg;

    // Converter speed-range code driven on the rate outputs
    typedef enum logic [1:0] {
        RATE_SINGLE = 2'b00,
        RATE_DOUBLE = 2'b01,
        RATE_QUAD   = 2'b10
    } rate_e;

    // Derived audio clocks, all registered from the frame counters
    typedef struct packed {
        logic bit_clk;
        logic word_clk;
        logic fb_clk;
    } clk_bundle_t;

    // Per-cycle strobes from the frame timer to the lanes
    typedef struct packed {
        logic shift;
        logic load;
        logic req;
    } frame_ctl_t;

    function automatic rate_e rate_from_mult(input int mult);
        case (mult)
            4:       return RATE_QUAD;
            2:       return RATE_DOUBLE;
            default: return RATE_SINGLE;
        endcase
    endfunction

endpackage

// File: rtl/i2s_quad_timing.sv
`timescale 1ns/1ps
module i2s_quad_timing
    import i2s_quad_pkg::*;
#(
    parameter int MCLK_PER_BIT = 4,
    parameter int SLOT_W       = 32
) (
    input  logic        clk,
    input  logic        rst,
    output clk_bundle_t clks_o,
    output frame_ctl_t  ctl_o
);
    localparam int BITS = 2 * SLOT_W;
    localparam int PH_W = $clog2(MCLK_PER_BIT);
    localparam int BI_W = $clog2(BITS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(MCLK_PER_BIT - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(MCLK_PER_BIT / 2);
    localparam logic [BI_W-1:0] BI_LAST = BI_W'(BITS - 1);
    localparam logic [BI_W-1:0] BI_SLOT = BI_W'(SLOT_W);

    logic [PH_W-1:0] phase, ph_nxt;
    logic [BI_W-1:0] bit_idx, bi_nxt;
    logic            ph_last, bi_last;
    clk_bundle_t     clks_q;
    logic            req_q;

    always_comb begin
        ph_last = (phase == PH_LAST);
        bi_last = (bit_idx == BI_LAST);
        ph_nxt  = ph_last ? '0 : phase + 1'b1;
        if (ph_last)
            bi_nxt = bi_last ? '0 : bit_idx + 1'b1;
        else
            bi_nxt = bit_idx;
    end

    // Clocks are registered from the next counter state so they
    // switch on the same master edge as the counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            bit_idx <= '0;
            clks_q  <= '0;
            req_q   <= 1'b0;
        end else begin
            phase           <= ph_nxt;
            bit_idx         <= bi_nxt;
            clks_q.bit_clk  <= (ph_nxt >= PH_HALF);
            clks_q.word_clk <= (bi_nxt >= BI_SLOT);
            clks_q.fb_clk   <= (bi_nxt >= BI_SLOT);
            req_q           <= ph_last && bi_last;
        end
    end

    assign clks_o    = clks_q;
    assign ctl_o.shift = ph_last;
    assign ctl_o.load  = ph_last && (bit_idx == '0);
    assign ctl_o.req   = req_q;

endmodule

// File: rtl/i2s_quad_lane.sv
`timescale 1ns/1ps
module i2s_quad_lane #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    output logic                sd
);
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int PAD_W   = SLOT_W - SAMPLE_W;

    logic [FRAME_W-1:0] image;
    logic [FRAME_W-1:0] shreg;
    logic               sd_q;

    assign image = {left, {PAD_W{1'b0}}, right, {PAD_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sd_q  <= 1'b0;
        end else if (load) begin
            sd_q  <= image[FRAME_W-1];
            shreg <= {image[FRAME_W-2:0], 1'b0};
        end else if (shift) begin
            sd_q  <= shreg[FRAME_W-1];
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end

    assign sd = sd_q;

endmodule

// File: rtl/i2s_quad_tx.sv
`timescale 1ns/1ps
module i2s_quad_tx
    import i2s_quad_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int SAMPLE_W     = 24,
    parameter int SLOT_W       = 32,
    parameter int MCLK_PER_BIT = 4,
    parameter int RATE_MULT    = 2
) (
    input  logic                      clk_mclk_i,
    input  logic                      rst_i,
    input  logic [LANES*SAMPLE_W-1:0] left_i,
    input  logic [LANES*SAMPLE_W-1:0] right_i,
    output logic                      sysclk_o,
    output logic                      bclk_o,
    output logic                      wclk_o,
    output logic                      fbclk_o,
    output logic [LANES-1:0]          sd_o,
    output logic [1:0]                rate_o,
    output logic                      frame_req_o
);
    localparam rate_e RATE_CFG = rate_from_mult(RATE_MULT);

    clk_bundle_t clks;
    frame_ctl_t  ctl;

    assign sysclk_o = clk_mclk_i;

    i2s_quad_timing #(
        .MCLK_PER_BIT(MCLK_PER_BIT),
        .SLOT_W      (SLOT_W)
    ) u_timing (
        .clk   (clk_mclk_i),
        .rst   (rst_i),
        .clks_o(clks),
        .ctl_o (ctl)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        i2s_quad_lane #(
            .SAMPLE_W(SAMPLE_W),
            .SLOT_W  (SLOT_W)
        ) u_lane (
            .clk  (clk_mclk_i),
            .rst  (rst_i),
            .shift(ctl.shift),
            .load (ctl.load),
            .left (left_i[k*SAMPLE_W +: SAMPLE_W]),
            .right(right_i[k*SAMPLE_W +: SAMPLE_W]),
            .sd   (sd_o[k])
        );
    end

    assign bclk_o      = clks.bit_clk;
    assign wclk_o      = clks.word_clk;
    assign fbclk_o     = clks.fb_clk;
    assign frame_req_o = ctl.req;
    assign rate_o      = RATE_CFG;

endmodule

// File: rtl/i2s_quad_chk.sv
`timescale 1ns/1ps
module i2s_quad_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bclk,
    input logic             wclk,
    input logic             fb,
    input logic             req,
    input logic [LANES-1:0] sd
);
    // R6
    sd_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sd != $past(sd)) |-> $fell(bclk));

    // R3
    wclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (wclk != $past(wclk)) |-> $fell(bclk));

    // R2
    bclk_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk) |=> bclk);

    // R2
    bclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bclk) |=> !bclk);

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R8
    req_pos_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> (!wclk && !bclk));

    // R4
    fb_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fb) |-> $rose(wclk));

endmodule

bind i2s_quad_tx i2s_quad_chk #(.LANES(LANES)) u_chk (
    .clk (clk_mclk_i),
    .rst (rst_i),
    .bclk(bclk_o),
    .wclk(wclk_o),
    .fb  (fbclk_o),
    .req (frame_req_o),
    .sd  (sd_o)
);

// File: tb/sim_i2s_quad_tx.sv
`timescale 1ns/1ps
module sim_i2s_quad_tx;
    localparam int LANES = 4;
    localparam int SW    = 24;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [LANES*SW-1:0]    left_i = '0;
    logic [LANES*SW-1:0]    right_i = '0;
    logic                   sysclk_o, bclk_o, wclk_o, fbclk_o, frame_req_o;
    logic [LANES-1:0]       sd_o;
    logic [1:0]             rate_o;

    logic [SW-1:0] cur_l [LANES];
    logic [SW-1:0] cur_r [LANES];
    int vectors = 0;
    int errors  = 0;
    int n       = 0;
    int fidx    = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    i2s_quad_tx u0 (
        .clk_mclk_i (clk),
        .rst_i      (rst),
        .left_i     (left_i),
        .right_i    (right_i),
        .sysclk_o   (sysclk_o),
        .bclk_o     (bclk_o),
        .wclk_o     (wclk_o),
        .fbclk_o    (fbclk_o),
        .sd_o       (sd_o),
        .rate_o     (rate_o),
        .frame_req_o(frame_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at n=%0d: actual %0h expected %0h", req, n, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] gen(input int f, input int lane, input int side);
        logic [31:0] h;
        case (f)
            0: return '0;
            1: return '1;
            2: return side ? 24'h000001 : 24'h800000;
            3: return side ? 24'h555555 : 24'hAAAAAA;
            default: begin
                h = (32'(f) * 32'h9E3779B1) ^ (32'(lane * 2 + side + 1) * 32'h85EBCA6B);
                return h[31:8];
            end
        endcase
    endfunction

    // R5: bit period b -> left bit 24-b (b=1..24), right bit 56-b (b=33..56), else 0
    function automatic logic exp_sd(input logic [SW-1:0] l, input logic [SW-1:0] r, input int b);
        if (b >= 1 && b <= 24) return l[24-b];
        if (b >= 33 && b <= 56) return r[56-b];
        return 1'b0;
    endfunction

    task automatic load_frame(input int f);
        for (int i = 0; i < LANES; i++) begin
            cur_l[i] = gen(f, i, 0);
            cur_r[i] = gen(f, i, 1);
            left_i[i*SW +: SW]  = cur_l[i];
            right_i[i*SW +: SW] = cur_r[i];
        end
    endtask

    task automatic scramble();
        for (int i = 0; i < LANES; i++) begin
            left_i[i*SW +: SW]  = ~cur_l[i];
            right_i[i*SW +: SW] = ~cur_r[i] ^ 24'h3C3C3C;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        fidx++;
        load_frame(fidx);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 bclk", 32'(bclk_o), 0);
        chk("R10 wclk", 32'(wclk_o), 0);
        chk("R10 fbclk", 32'(fbclk_o), 0);
        chk("R10 sd", 32'(sd_o), 0);
        chk("R10 req", 32'(frame_req_o), 0);
        chk("R9 rate", 32'(rate_o), 32'h1);
        rst = 1'b0;
        n = 0;
    endtask

    task automatic run(input int cycles);
        int c, b;
        repeat (cycles) begin
            @(posedge clk);
            n++;
            #1;
            chk("R1 sysclk high", 32'(sysclk_o), 1);
            @(negedge clk);
            c = n % 256;
            b = c / 4;
            chk("R1 sysclk low", 32'(sysclk_o), 0);
            chk("R2 bclk", 32'(bclk_o), 32'((c % 4) >= 2));
            chk("R3 wclk", 32'(wclk_o), 32'(b >= 32));
            chk("R4 fbclk", 32'(fbclk_o), 32'(c >= 128));
            chk("R8 req", 32'(frame_req_o), 32'(c == 0));
            chk("R9 rate", 32'(rate_o), 32'h1);
            for (int i = 0; i < LANES; i++)
                chk("R5 R7 sd", 32'(sd_o[i]), 32'(exp_sd(cur_l[i], cur_r[i], b)));
            if (c == 0) begin
                fidx++;
                load_frame(fidx);
            end
            // R7: inputs changed after capture must not reach the wire
            if (c == 100 && fidx[0]) scramble();
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        load_frame(0);
        apply_reset();
        run(256 * 18 + 137);
        // R10: reset in mid-frame, dividers restart at phase zero
        apply_reset();
        run(256 * 22);
        done = 1;
        summary();
        $finish;
    end

endmodule